// File: doc/BRIEF.md
# Auto Power-Down and Wake Controller

This block governs the low-power state of a disk-controller core. It watches single-cycle host register accesses, the external reset pin and the two software reset bits carried by host writes. From these it keeps one of four states: reset sequence, running, powered down, or settling after a wake. Software requests power-down with a write to the data-rate select register. An optional automatic mode also enters power-down when the core has been idle and untouched for a set number of clocks.

While the block is powered down, every drive-side output from the core is forced inactive and its output enable is withdrawn. There are two ways out. Any reset source runs the normal reset sequence. An access to the main status or data register wakes the block without any reset, so the core keeps all its state. After that kind of wake, the request-for-master flag stays low for a programmable settling count before the host may move data. Separate flags report the power-down state and the idle state.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While rst_pin is high, and for RST_CYC (default 4) clock edges after it falls, core_rst_o is 1 and pd_o is 0. Then core_rst_o falls and the block runs.
- R2: Two writes are software resets: a write to offset 4 with bit 7 = 1, and a write to offset 2 with bit 2 = 0. Either one, in any state including power-down, sets core_rst_o = 1 and pd_o = 0 from the next cycle. core_rst_o stays high for RST_CYC cycles.
- R3: A write to offset 4 with bit 6 = 1 and bit 7 = 0, made while running, sets pd_o = 1 from the next cycle. If bit 7 is also 1, the reset takes effect and the power-down request is dropped.
- R4: While powered down, these accesses leave pd_o = 1: reads and writes at offsets 0, 1, 3, 6 and 7, reads at offset 2, and writes at offset 2 with bit 2 = 1.
- R5: While powered down, a read or a write at offset 4 or 5 that is not a reset clears pd_o in the next cycle without raising core_rst_o. rqm_o then stays 0 for SETTLE_CYC (default 8) cycles, after which it follows rqm_core.
- R6: When pd_o = 1, drv_oe_o = 0 and drv_out_o = 0. Otherwise drv_oe_o = 1 and drv_out_o = drv_out_core.
- R7: idle_o is 1 when powered down, or when running with cmd_busy = 0. It is 0 during the reset sequence, during settling, and while running with cmd_busy = 1.
- R8: With auto_pd_en = 1 while running, pd_o rises IDLE_CYC (default 16) cycles after the last cycle that had a host access or cmd_busy = 1. Any access or busy cycle restarts the count. With auto_pd_en = 0 the block never powers down by itself.
- R9: rqm_o is 0 throughout the reset sequence and while powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| acc_valid | input | 1 | One-cycle host register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register offset of the access |
| acc_wdata | input | DATA_W | Write data |
| cmd_busy | input | 1 | Core has a command in progress |
| auto_pd_en | input | 1 | Enables automatic power-down on idle |
| rqm_core | input | 1 | Core's request-for-master flag |
| drv_out_core | input | DRV_W | Core's drive-side output levels |
| rqm_o | output | 1 | Gated request-for-master flag |
| drv_out_o | output | DRV_W | Gated drive-side outputs |
| drv_oe_o | output | 1 | Drive-side output enable |
| pd_o | output | 1 | Powered-down indicator |
| idle_o | output | 1 | Idle indicator |
| core_rst_o | output | 1 | Core reset sequence active |

## Verification
The assertions assume that acc_valid lasts one cycle per access. They also assume that acc_addr, acc_write and acc_wdata are known whenever acc_valid is high, and that rst_pin changes only away from the clock edge. The bench drives every access from a task that raises the strobe at a falling edge for exactly one cycle. It sets fixed values for the other access fields in that same cycle, and moves rst_pin only at falling edges. Because auto_pd_en is held at 0 outside the automatic-mode tests, the other checks never meet an unplanned power-down.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [1:0] {
        ST_RST    = 2'd0,
        ST_RUN    = 2'd1,
        ST_PD     = 2'd2,
        ST_SETTLE = 2'd3
    } pstate_e;
endpackage

// File: rtl/pwr_wake_decode.sv
module pwr_wake_decode #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int DOR_OFS     = 2,
    parameter int DSR_OFS     = 4,
    parameter int FIFO_OFS    = 5,
    parameter int DOR_RST_BIT = 2,
    parameter int DSR_RST_BIT = 7,
    parameter int DSR_PD_BIT  = 6
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              wake_o,
    output logic              swrst_o,
    output logic              pdreq_o
);
    localparam logic [ADDR_W-1:0] DOR_A  = ADDR_W'(DOR_OFS);
    localparam logic [ADDR_W-1:0] DSR_A  = ADDR_W'(DSR_OFS);
    localparam logic [ADDR_W-1:0] FIFO_A = ADDR_W'(FIFO_OFS);

    logic hit_dor, hit_dsr, hit_fifo, wr_dor, wr_dsr;

    always_comb begin
        hit_dor  = acc_valid && (acc_addr == DOR_A);
        hit_dsr  = acc_valid && (acc_addr == DSR_A);
        hit_fifo = acc_valid && (acc_addr == FIFO_A);
        wr_dor   = hit_dor && acc_write;
        wr_dsr   = hit_dsr && acc_write;
        wake_o   = hit_dsr || hit_fifo;
        swrst_o  = (wr_dsr && acc_wdata[DSR_RST_BIT]) ||
                   (wr_dor && !acc_wdata[DOR_RST_BIT]);
        pdreq_o  = wr_dsr && acc_wdata[DSR_PD_BIT] && !acc_wdata[DSR_RST_BIT];
    end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
#(
    parameter int RST_CYC    = 4,
    parameter int SETTLE_CYC = 8,
    parameter int IDLE_CYC   = 16
) (
    input  logic    clk,
    input  logic    rst_pin,
    input  logic    acc_valid,
    input  logic    cmd_busy,
    input  logic    auto_pd_en,
    input  logic    wake,
    input  logic    swrst,
    input  logic    pdreq,
    output pstate_e state_o
);
    localparam int SEQ_MAX = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int CW = (SEQ_MAX > 1) ? $clog2(SEQ_MAX) : 1;
    localparam int IW = $clog2(IDLE_CYC);
    localparam logic [CW-1:0] RST_LOAD    = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYC - 1);
    localparam logic [IW-1:0] IDLE_LAST   = IW'(IDLE_CYC - 1);

    typedef struct packed {
        pstate_e       st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idle;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RST: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_RUN;
                    r_d.idle = '0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RUN: begin
                if (!auto_pd_en || cmd_busy || acc_valid) begin
                    r_d.idle = '0;
                end else if (r_q.idle == IDLE_LAST) begin
                    r_d.st   = ST_PD;
                    r_d.idle = '0;
                end else begin
                    r_d.idle = r_q.idle + 1'b1;
                end
                if (pdreq) r_d.st = ST_PD;
            end
            ST_PD: begin
                if (wake) begin
                    r_d.st  = ST_SETTLE;
                    r_d.cnt = SETTLE_LOAD;
                end
            end
            ST_SETTLE: begin
                if (pdreq) begin
                    r_d.st = ST_PD;
                end else if (r_q.cnt == '0) begin
                    r_d.st   = ST_RUN;
                    r_d.idle = '0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_RST;
        endcase
        if (swrst) begin
            r_d.st   = ST_RST;
            r_d.cnt  = RST_LOAD;
            r_d.idle = '0;
        end
    end

    always_ff @(posedge clk or posedge rst_pin) begin
        if (rst_pin) begin
            r_q.st   <= ST_RST;
            r_q.cnt  <= RST_LOAD;
            r_q.idle <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

    // R1
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst_pin)
        (r_q.st == ST_RST && r_q.cnt != '0 && !swrst) |=> (r_q.st == ST_RST));

    // R8
    auto_off_chk: assert property (@(posedge clk) disable iff (rst_pin)
        (r_q.st == ST_RUN && !auto_pd_en && !pdreq && !swrst) |=> (r_q.st == ST_RUN));

    // R5
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst_pin)
        (r_q.st == ST_SETTLE && r_q.cnt != '0 && !pdreq && !swrst) |=> (r_q.st == ST_SETTLE));
endmodule

// File: rtl/pwr_out_gate.sv
module pwr_out_gate #(
    parameter int DRV_W = 6
) (
    input  logic             pd,
    input  logic [DRV_W-1:0] drv_in,
    output logic [DRV_W-1:0] drv_out,
    output logic             drv_oe
);
    for (genvar gi = 0; gi < DRV_W; gi++) begin : g_bit
        assign drv_out[gi] = drv_in[gi] && !pd;
    end
    assign drv_oe = !pd;
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int DRV_W      = 6,
    parameter int RST_CYC    = 4,
    parameter int SETTLE_CYC = 8,
    parameter int IDLE_CYC   = 16
) (
    input  logic              clk,
    input  logic              rst_pin,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              cmd_busy,
    input  logic              auto_pd_en,
    input  logic              rqm_core,
    input  logic [DRV_W-1:0]  drv_out_core,
    output logic              rqm_o,
    output logic [DRV_W-1:0]  drv_out_o,
    output logic              drv_oe_o,
    output logic              pd_o,
    output logic              idle_o,
    output logic              core_rst_o
);
    logic    wake, swrst, pdreq;
    pstate_e st;

    pwr_wake_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .wake_o    (wake),
        .swrst_o   (swrst),
        .pdreq_o   (pdreq)
    );

    pwr_fsm #(
        .RST_CYC   (RST_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .IDLE_CYC  (IDLE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_pin   (rst_pin),
        .acc_valid (acc_valid),
        .cmd_busy  (cmd_busy),
        .auto_pd_en(auto_pd_en),
        .wake      (wake),
        .swrst     (swrst),
        .pdreq     (pdreq),
        .state_o   (st)
    );

    always_comb begin
        pd_o       = (st == ST_PD);
        core_rst_o = (st == ST_RST);
        rqm_o      = rqm_core && (st == ST_RUN);
        idle_o     = (st == ST_PD) || ((st == ST_RUN) && !cmd_busy);
    end

    pwr_out_gate #(.DRV_W(DRV_W)) u_gate (
        .pd     (pd_o),
        .drv_in (drv_out_core),
        .drv_out(drv_out_o),
        .drv_oe (drv_oe_o)
    );

    // R2
    swrst_enter_chk: assert property (@(posedge clk) disable iff (rst_pin)
        swrst |=> (core_rst_o && !pd_o));

    // R3
    pd_enter_chk: assert property (@(posedge clk) disable iff (rst_pin)
        (!pd_o && !core_rst_o && pdreq && !swrst) |=> pd_o);

    // R4
    pd_stay_chk: assert property (@(posedge clk) disable iff (rst_pin)
        (pd_o && !wake && !swrst) |=> pd_o);

    // R5
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst_pin)
        (pd_o && wake && !swrst) |=> (!pd_o && !core_rst_o && !rqm_o));

    // R6
    drv_gate_chk: assert property (@(posedge clk) disable iff (rst_pin)
        pd_o |-> (!drv_oe_o && drv_out_o == '0));

    // R9
    rqm_block_chk: assert property (@(posedge clk) disable iff (rst_pin)
        (core_rst_o || pd_o) |-> !rqm_o);
endmodule

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int DRV_W  = 6;
    localparam int RSTC   = 4;
    localparam int SETC   = 8;
    localparam int IDLEC  = 16;

    logic clk = 1'b0;
    logic rst_pin = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [DATA_W-1:0] acc_wdata = '0;
    logic cmd_busy = 1'b0, auto_pd_en = 1'b0, rqm_core = 1'b1;
    logic [DRV_W-1:0] drv_out_core = 6'h2D;
    logic rqm_o, drv_oe_o, pd_o, idle_o, core_rst_o;
    logic [DRV_W-1:0] drv_out_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwr_wake_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DRV_W(DRV_W),
        .RST_CYC(RSTC), .SETTLE_CYC(SETC), .IDLE_CYC(IDLEC)
    ) u_dut (
        .clk(clk), .rst_pin(rst_pin), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .cmd_busy(cmd_busy),
        .auto_pd_en(auto_pd_en), .rqm_core(rqm_core), .drv_out_core(drv_out_core),
        .rqm_o(rqm_o), .drv_out_o(drv_out_o), .drv_oe_o(drv_oe_o), .pd_o(pd_o),
        .idle_o(idle_o), .core_rst_o(core_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic wr, input logic [DATA_W-1:0] d);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_wdata = d;
        step();
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0; acc_addr = '0;
    endtask

    task automatic run_reset_seq(input string req);
        check(req, {31'd0, core_rst_o}, 32'd1);
        check(req, {31'd0, pd_o}, 32'd0);
        check("R9", {31'd0, rqm_o}, 32'd0);
        check("R7", {31'd0, idle_o}, 32'd0);
        for (int i = 1; i < RSTC; i++) begin
            step();
            check(req, {31'd0, core_rst_o}, 32'd1);
        end
        step();
        check(req, {31'd0, core_rst_o}, 32'd0);
        check(req, {31'd0, rqm_o}, 32'd1);
    endtask

    task automatic enter_pd();
        access(3'd4, 1'b1, 8'h40);
        check("R3", {31'd0, pd_o}, 32'd1);
    endtask

    task automatic wake_and_settle(input logic [ADDR_W-1:0] a, input logic wr);
        access(a, wr, 8'h00);
        check("R5", {31'd0, pd_o}, 32'd0);
        check("R5", {31'd0, core_rst_o}, 32'd0);
        check("R5", {31'd0, rqm_o}, 32'd0);
        check("R7", {31'd0, idle_o}, 32'd0);
        for (int i = 1; i < SETC; i++) begin
            step();
            check("R5", {31'd0, rqm_o}, 32'd0);
        end
        step();
        check("R5", {31'd0, rqm_o}, 32'd1);
        check("R5", {31'd0, core_rst_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while pin held
        check("R1", {31'd0, core_rst_o}, 32'd1);
        check("R1", {31'd0, pd_o}, 32'd0);
        check("R9", {31'd0, rqm_o}, 32'd0);
        rst_pin = 1'b0;
        for (int i = 1; i < RSTC; i++) begin
            step();
            check("R1", {31'd0, core_rst_o}, 32'd1);
        end
        step();
        check("R1", {31'd0, core_rst_o}, 32'd0);
        check("R7", {31'd0, idle_o}, 32'd1);
        check("R6", {31'd0, drv_oe_o}, 32'd1);
        check("R6", {26'd0, drv_out_o}, {26'd0, drv_out_core});

        // R3 / R6 / R7 in power-down
        enter_pd();
        check("R6", {31'd0, drv_oe_o}, 32'd0);
        check("R6", {26'd0, drv_out_o}, 32'd0);
        check("R7", {31'd0, idle_o}, 32'd1);
        check("R9", {31'd0, rqm_o}, 32'd0);
        cmd_busy = 1'b1;
        step();
        check("R7", {31'd0, idle_o}, 32'd1);
        cmd_busy = 1'b0;

        // R4: non-waking offsets sweep
        for (int a = 0; a < 8; a++) begin
            for (int w = 0; w < 2; w++) begin
                if (a != 4 && a != 5) begin
                    access(3'(a), 1'(w), 8'hFF);
                    step();
                    check("R4", {31'd0, pd_o}, 32'd1);
                    check("R6", {31'd0, drv_oe_o}, 32'd0);
                end
            end
        end

        // R5: waking offsets sweep
        for (int a = 4; a < 6; a++) begin
            for (int w = 0; w < 2; w++) begin
                wake_and_settle(3'(a), 1'(w));
                check("R6", {26'd0, drv_out_o}, {26'd0, drv_out_core});
                enter_pd();
            end
        end

        // R2: software resets from power-down
        access(3'd4, 1'b1, 8'h80);
        run_reset_seq("R2");
        enter_pd();
        access(3'd2, 1'b1, 8'h00);
        run_reset_seq("R2");
        // R2: from running, including reset-over-power-down priority (R3)
        access(3'd4, 1'b1, 8'hC0);
        check("R3", {31'd0, pd_o}, 32'd0);
        run_reset_seq("R2");
        access(3'd2, 1'b1, 8'hFB);
        run_reset_seq("R2");
        // non-reset DOR write while running keeps running
        access(3'd2, 1'b1, 8'h04);
        check("R2", {31'd0, core_rst_o}, 32'd0);

        // R8: automatic power-down
        auto_pd_en = 1'b1;
        access(3'd0, 1'b0, 8'h00);
        for (int i = 1; i < IDLEC; i++) begin
            step();
            check("R8", {31'd0, pd_o}, 32'd0);
        end
        step();
        check("R8", {31'd0, pd_o}, 32'd1);
        auto_pd_en = 1'b0;
        wake_and_settle(3'd5, 1'b0);

        // R8: restart on access
        auto_pd_en = 1'b1;
        access(3'd1, 1'b0, 8'h00);
        for (int i = 1; i < IDLEC - 2; i++) step();
        access(3'd7, 1'b0, 8'h00);
        for (int i = 1; i < IDLEC; i++) begin
            step();
            check("R8", {31'd0, pd_o}, 32'd0);
        end
        step();
        check("R8", {31'd0, pd_o}, 32'd1);
        auto_pd_en = 1'b0;
        wake_and_settle(3'd4, 1'b0);

        // R8 / R7: busy blocks the idle count
        auto_pd_en = 1'b1;
        cmd_busy = 1'b1;
        for (int i = 0; i < 2 * IDLEC; i++) step();
        check("R8", {31'd0, pd_o}, 32'd0);
        check("R7", {31'd0, idle_o}, 32'd0);
        cmd_busy = 1'b0;
        for (int i = 1; i < IDLEC; i++) begin
            step();
            check("R8", {31'd0, pd_o}, 32'd0);
        end
        step();
        check("R8", {31'd0, pd_o}, 32'd1);
        auto_pd_en = 1'b0;
        wake_and_settle(3'd5, 1'b1);

        // R8: disabled mode never powers down
        for (int i = 0; i < 3 * IDLEC; i++) step();
        check("R8", {31'd0, pd_o}, 32'd0);
        check("R7", {31'd0, idle_o}, 32'd1);

        // R1: pin reset from power-down
        enter_pd();
        rst_pin = 1'b1;
        step();
        check("R1", {31'd0, pd_o}, 32'd0);
        check("R1", {31'd0, core_rst_o}, 32'd1);
        rst_pin = 1'b0;
        for (int i = 1; i < RSTC; i++) begin
            step();
            check("R1", {31'd0, core_rst_o}, 32'd1);
        end
        step();
        check("R1", {31'd0, core_rst_o}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule